// File: doc/BRIEF.md
# CAN Frame Queue Port

This block sits between a 32-bit register bus and a CAN protocol engine and holds whole frames in two queues, one per direction. A frame is four words: the identifier word, the length word (data length code in bits 31:28), and two data words. Software builds an outgoing frame one word at a time in staging registers. The frame enters the transmit queue as one entry, and only on the write that completes it. The engine takes frames from the head of the transmit queue with a valid/ready handshake.

Incoming frames are pushed whole by the engine in a single cycle. Software reads the head frame word by word. The read of the last data word removes the frame, so an entry is never partly consumed. The block raises a transmit-full level, a one-cycle pulse when the transmit queue drains, a receive-not-empty level, and one-cycle pulses for each received frame that is accepted and for each one that is dropped.

Top module: `can_frame_fifo_port`

## Requirements
- R1: After reset both queues are empty: tx_frame_valid, tx_full, rx_not_empty, tx_empty_pulse, rx_ok and rx_overflow are all 0.
- R2: A bus write to offset 0x30 stages the identifier, 0x34 stages the length code from wdata[31:28], and 0x38 stages data word 1. A write to 0x3C commits the staged frame with that write's data as data word 2. Frames reach the engine in commit order, one entry per commit.
- R3: A frame is remote when identifier bit 19 is 1 and bit 0 is 1, or when bit 19 is 0 and bit 20 is 1. For a remote identifier the write to 0x34 commits the frame, and both data words are zero.
- R4: Every commit clears the staging registers, whether the queue accepts the frame or not. A later commit that rewrites only 0x3C therefore carries identifier 0, length 0 and data word 1 equal to 0.
- R5: tx_full is 1 exactly while the transmit queue holds TX_DEPTH frames. A commit while the queue is full is discarded, and the queued frames are left unchanged.
- R6: tx_empty_pulse is 1 for one cycle, in the cycle after the handshake that removes the last transmit frame, and at no other time.
- R7: Bus reads return the receive head at 0x50 (identifier), 0x54 (length code in bits 31:28, other bits 0), 0x58 (data word 1) and 0x5C (data word 2). Only a read of 0x5C removes the head frame.
- R8: A read of 0x5C removes the head frame even when its length code is 0. With the receive queue empty, every receive offset reads 0, and a read of 0x5C has no effect.
- R9: rx_not_empty is 1 exactly while the receive queue holds at least one frame.
- R10: rx_ok pulses for one cycle, in the cycle after the engine pushes a frame into a receive queue that is not full.
- R11: A push into a full receive queue is dropped. rx_overflow pulses in the next cycle, rx_ok stays 0, and the queued frames are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_rd_en | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | Bus word offset |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data (combinational) |
| tx_frame_valid | output | 1 | Transmit head frame available |
| tx_frame_ready | input | 1 | Engine takes the transmit head |
| tx_id | output | 32 | Transmit head identifier word |
| tx_len | output | 4 | Transmit head length code |
| tx_dw1 | output | 32 | Transmit head data word 1 |
| tx_dw2 | output | 32 | Transmit head data word 2 |
| rx_push | input | 1 | Engine delivers a received frame |
| rx_id | input | 32 | Received identifier word |
| rx_len | input | 4 | Received length code |
| rx_dw1 | input | 32 | Received data word 1 |
| rx_dw2 | input | 32 | Received data word 2 |
| tx_full | output | 1 | Transmit queue has no free entry |
| tx_empty_pulse | output | 1 | Transmit queue just drained |
| rx_not_empty | output | 1 | Receive queue holds a frame |
| rx_ok | output | 1 | Received frame accepted |
| rx_overflow | output | 1 | Received frame dropped |

## Verification
The hardest case to reach is a discarded commit whose cleared staging state later shows up at the engine. To get there, the stimulus fills the transmit queue while the engine holds ready low and stages a frame with a recognisable identifier. It commits that frame into the full queue and drains the queue. It then commits with only a data-word-2 write: the frame that appears must carry a zero identifier and no trace of the discarded one. The receive side is filled to depth and pushed once more. Every queued identifier is then read back in order, and the dropped frame must be absent.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

  typedef struct packed {
    logic [31:0] id;
    logic [3:0]  len;
    logic [31:0] dw1;
    logic [31:0] dw2;
  } cfp_frame_t;

  // Bus word offsets (the committing and popping offsets carry behaviour)
  localparam logic [7:0] OFS_TX_ID  = 8'h30;
  localparam logic [7:0] OFS_TX_LEN = 8'h34;
  localparam logic [7:0] OFS_TX_DW1 = 8'h38;
  localparam logic [7:0] OFS_TX_DW2 = 8'h3C;
  localparam logic [7:0] OFS_RX_ID  = 8'h50;
  localparam logic [7:0] OFS_RX_LEN = 8'h54;
  localparam logic [7:0] OFS_RX_DW1 = 8'h58;
  localparam logic [7:0] OFS_RX_DW2 = 8'h5C;

  localparam int BIT_EXT = 19;
  localparam int BIT_SUB = 20;
  localparam int BIT_RMT = 0;

  // Remote decision: extended frames use bit 0, base frames use bit 20
  function automatic logic cfp_is_remote(input logic [31:0] id);
    return id[BIT_EXT] ? id[BIT_RMT] : id[BIT_SUB];
  endfunction

  function automatic logic [3:0] cfp_len_of(input logic [31:0] word);
    return word[31:28];
  endfunction

  function automatic logic [31:0] cfp_len_word(input logic [3:0] len);
    return {len, 28'd0};
  endfunction

endpackage

// File: rtl/cfp_frame_fifo.sv
module cfp_frame_fifo
  import cfp_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  cfp_frame_t push_frame,
  input  logic       pop,
  output cfp_frame_t head,
  output logic       full,
  output logic       empty,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic       push_ok,
  output logic       pop_ok
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam bit POW2  = (DEPTH > 1) && ((DEPTH & (DEPTH - 1)) == 0);

  cfp_frame_t       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = empty ? '0 : mem[rd_ptr];

  generate
    if (POW2) begin : g_wrap_nat
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_frame;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_nxt;
      if (pop_ok)  rd_ptr <= rd_nxt;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/cfp_tx_stager.sv
module cfp_tx_stager
  import cfp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic              commit,
  output logic              commit_remote,
  output cfp_frame_t        commit_frame
);
  logic [31:0] id_q, dw1_q;
  logic [3:0]  len_q;
  logic hit_id, hit_len, hit_dw1, hit_dw2;

  assign hit_id  = wr_en && (addr == ADDR_W'(OFS_TX_ID));
  assign hit_len = wr_en && (addr == ADDR_W'(OFS_TX_LEN));
  assign hit_dw1 = wr_en && (addr == ADDR_W'(OFS_TX_DW1));
  assign hit_dw2 = wr_en && (addr == ADDR_W'(OFS_TX_DW2));

  assign commit_remote = hit_len && cfp_is_remote(id_q);
  assign commit        = commit_remote || hit_dw2;

  always_comb begin
    commit_frame.id  = id_q;
    commit_frame.len = hit_len ? cfp_len_of(wdata) : len_q;
    if (commit_remote) begin
      commit_frame.dw1 = '0;
      commit_frame.dw2 = '0;
    end else begin
      commit_frame.dw1 = dw1_q;
      commit_frame.dw2 = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || commit) begin
      id_q  <= '0;
      len_q <= '0;
      dw1_q <= '0;
    end else begin
      if (hit_id)  id_q  <= wdata;
      if (hit_len) len_q <= cfp_len_of(wdata);
      if (hit_dw1) dw1_q <= wdata;
    end
  end
endmodule

// File: rtl/cfp_rx_reader.sv
module cfp_rx_reader
  import cfp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  cfp_frame_t        head,
  input  logic              has_frame,
  output logic [31:0]       rdata,
  output logic              pop
);
  always_comb begin
    rdata = '0;
    if (has_frame) begin
      if (addr == ADDR_W'(OFS_RX_ID))  rdata = head.id;
      if (addr == ADDR_W'(OFS_RX_LEN)) rdata = cfp_len_word(head.len);
      if (addr == ADDR_W'(OFS_RX_DW1)) rdata = head.dw1;
      if (addr == ADDR_W'(OFS_RX_DW2)) rdata = head.dw2;
    end
  end

  assign pop = rd_en && has_frame && (addr == ADDR_W'(OFS_RX_DW2));
endmodule

// File: rtl/can_frame_fifo_port.sv
module can_frame_fifo_port
  import cfp_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_frame_valid,
  input  logic              tx_frame_ready,
  output logic [31:0]       tx_id,
  output logic [3:0]        tx_len,
  output logic [31:0]       tx_dw1,
  output logic [31:0]       tx_dw2,
  input  logic              rx_push,
  input  logic [31:0]       rx_id,
  input  logic [3:0]        rx_len,
  input  logic [31:0]       rx_dw1,
  input  logic [31:0]       rx_dw2,
  output logic              tx_full,
  output logic              tx_empty_pulse,
  output logic              rx_not_empty,
  output logic              rx_ok,
  output logic              rx_overflow
);
  localparam int TX_CNT_W = $clog2(TX_DEPTH+1);
  localparam int RX_CNT_W = $clog2(RX_DEPTH+1);

  // Named internal events
  logic                tx_commit, tx_commit_remote, tx_push_ok, tx_pop_ok, tx_empty;
  logic                rx_push_ok, rx_pop, rx_pop_ok, rx_full, rx_empty, rx_drop;
  logic [TX_CNT_W-1:0] tx_count;
  logic [RX_CNT_W-1:0] rx_count;
  cfp_frame_t          tx_stage_frame, tx_head, rx_in_frame, rx_head;
  logic                tx_last_out;

  cfp_tx_stager #(.ADDR_W(ADDR_W)) stager_i (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .commit(tx_commit), .commit_remote(tx_commit_remote),
    .commit_frame(tx_stage_frame)
  );

  cfp_frame_fifo #(.DEPTH(TX_DEPTH)) tx_fifo_i (
    .clk(clk), .rst_n(rst_n), .push(tx_commit), .push_frame(tx_stage_frame),
    .pop(tx_frame_ready), .head(tx_head), .full(tx_full), .empty(tx_empty),
    .count(tx_count), .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  assign tx_frame_valid = !tx_empty;
  assign tx_id  = tx_head.id;
  assign tx_len = tx_head.len;
  assign tx_dw1 = tx_head.dw1;
  assign tx_dw2 = tx_head.dw2;

  always_comb begin
    rx_in_frame.id  = rx_id;
    rx_in_frame.len = rx_len;
    rx_in_frame.dw1 = rx_dw1;
    rx_in_frame.dw2 = rx_dw2;
  end

  cfp_frame_fifo #(.DEPTH(RX_DEPTH)) rx_fifo_i (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .push_frame(rx_in_frame),
    .pop(rx_pop), .head(rx_head), .full(rx_full), .empty(rx_empty),
    .count(rx_count), .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  cfp_rx_reader #(.ADDR_W(ADDR_W)) reader_i (
    .rd_en(bus_rd_en), .addr(bus_addr), .head(rx_head),
    .has_frame(!rx_empty), .rdata(bus_rdata), .pop(rx_pop)
  );

  assign rx_not_empty = !rx_empty;
  assign rx_drop      = rx_push && rx_full;
  assign tx_last_out  = tx_pop_ok && !tx_push_ok && (tx_count == TX_CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_ok          <= 1'b0;
      rx_overflow    <= 1'b0;
      tx_empty_pulse <= 1'b0;
    end else begin
      rx_ok          <= rx_push_ok;
      rx_overflow    <= rx_drop;
      tx_empty_pulse <= tx_last_out;
    end
  end
endmodule

// File: rtl/cfp_checker.sv
module cfp_checker #(
  parameter int TX_CNT_W = 3,
  parameter int RX_CNT_W = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rx_push,
  input logic                rx_full,
  input logic                rx_pop_ok,
  input logic [RX_CNT_W-1:0] rx_count,
  input logic                rx_ok,
  input logic                rx_overflow,
  input logic                rx_not_empty,
  input logic                tx_commit,
  input logic                tx_full,
  input logic                tx_pop_ok,
  input logic [TX_CNT_W-1:0] tx_count,
  input logic                tx_frame_valid,
  input logic                tx_empty_pulse
);
  AST_RXOK_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && !rx_full |=> rx_ok); // R10
  AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_full |=> rx_overflow && !rx_ok); // R11
  AST_DROP_KEEPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_full && !rx_pop_ok |=> rx_count == $past(rx_count)); // R11
  AST_RXOK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ok |-> rx_not_empty); // R9
  AST_RX_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop_ok && !rx_push |=> rx_count == RX_CNT_W'($past(rx_count) - 1'b1)); // R7
  AST_TX_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_commit && tx_full && !tx_pop_ok |=> tx_full && (tx_count == $past(tx_count))); // R5
  AST_TXEMPTY_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_pulse |-> !tx_frame_valid && $past(tx_pop_ok)); // R6
endmodule

bind can_frame_fifo_port cfp_checker #(.TX_CNT_W(TX_CNT_W), .RX_CNT_W(RX_CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_full(rx_full),
  .rx_pop_ok(rx_pop_ok), .rx_count(rx_count), .rx_ok(rx_ok),
  .rx_overflow(rx_overflow), .rx_not_empty(rx_not_empty),
  .tx_commit(tx_commit), .tx_full(tx_full), .tx_pop_ok(tx_pop_ok),
  .tx_count(tx_count), .tx_frame_valid(tx_frame_valid),
  .tx_empty_pulse(tx_empty_pulse)
);

// File: tb/can_frame_fifo_port_tb.sv
module can_frame_fifo_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TXD = 4;
  localparam int RXD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr_en = 0, bus_rd_en = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tx_frame_valid, tx_frame_ready = 0;
  logic [31:0] tx_id, tx_dw1, tx_dw2;
  logic [3:0] tx_len;
  logic rx_push = 0;
  logic [31:0] rx_id = '0, rx_dw1 = '0, rx_dw2 = '0;
  logic [3:0] rx_len = '0;
  logic tx_full, tx_empty_pulse, rx_not_empty, rx_ok, rx_overflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_frame_fifo_port #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .ADDR_W(8)) dut_i (.*);

  // {id, len, dw1, dw2}
  localparam logic [99:0] TXV [6] = '{
    {32'h48C00000, 4'h8, 32'h11223344, 32'h55667788},
    {32'hFFF00000, 4'h2, 32'hAAAAAAAA, 32'hBBBBBBBB},
    {32'h2469ABCE, 4'h4, 32'hDEADBEEF, 32'hCAFEF00D},
    {32'h2469ABCF, 4'h0, 32'h12121212, 32'h34343434},
    {32'h00180000, 4'h1, 32'h01020304, 32'h05060708},
    {32'h00000001, 4'hF, 32'h0F0F0F0F, 32'hF0F0F0F0}
  };

  function automatic bit bench_remote(input logic [31:0] id);
    if (((id >> 19) & 32'd1) != 0) return (id & 32'd1) != 0;
    return ((id >> 20) & 32'd1) != 0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd_en = 0;
  endtask

  task automatic eng_pop();
    @(negedge clk);
    tx_frame_ready = 1;
    @(negedge clk);
    tx_frame_ready = 0;
    #1;
  endtask

  task automatic eng_push(input logic [31:0] id, input logic [3:0] len,
                          input logic [31:0] d1, input logic [31:0] d2);
    @(negedge clk);
    rx_push = 1; rx_id = id; rx_len = len; rx_dw1 = d1; rx_dw2 = d2;
    @(negedge clk);
    rx_push = 0;
    #1;
  endtask

  task automatic read_frame(input string req, input logic [31:0] id, input logic [3:0] len,
                            input logic [31:0] d1, input logic [31:0] d2);
    logic [31:0] v;
    bus_read(8'h50, v); check({req, " rx id"}, v, id);
    bus_read(8'h54, v); check({req, " rx len word"}, v, {len, 28'd0});
    bus_read(8'h58, v); check({req, " rx dw1"}, v, d1);
    bus_read(8'h5C, v); check({req, " rx dw2"}, v, d2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 tx_frame_valid", 32'(tx_frame_valid), 0);
    check("R1 tx_full", 32'(tx_full), 0);
    check("R1 rx_not_empty", 32'(rx_not_empty), 0);
    check("R1 pulses", {29'd0, tx_empty_pulse, rx_ok, rx_overflow}, 0);

    // R2 R3 R6 vector walk
    foreach (TXV[i]) begin
      logic [31:0] vid, vd1, vd2;
      logic [3:0]  vlen;
      bit rem;
      {vid, vlen, vd1, vd2} = TXV[i];
      rem = bench_remote(vid);
      bus_write(8'h30, vid);
      bus_write(8'h34, {vlen, 28'h0ABCDEF});
      if (!rem) begin
        bus_write(8'h38, vd1);
        bus_write(8'h3C, vd2);
      end
      check("R2 R3 tx valid after commit", 32'(tx_frame_valid), 1);
      check("R2 tx id", tx_id, vid);
      check("R2 tx len", 32'(tx_len), 32'(vlen));
      check("R3 tx dw1", tx_dw1, rem ? 32'h0 : vd1);
      check("R3 tx dw2", tx_dw2, rem ? 32'h0 : vd2);
      eng_pop();
      check("R6 empty pulse on last frame", 32'(tx_empty_pulse), 1);
      check("R6 queue drained", 32'(tx_frame_valid), 0);
      @(negedge clk);
      check("R6 pulse one cycle", 32'(tx_empty_pulse), 0);
    end

    // R5 fill transmit queue, then commit into full queue
    for (int k = 0; k < TXD; k++) begin
      bus_write(8'h30, 32'h10000000 + 32'(k * 2));
      bus_write(8'h3C, 32'(k));
    end
    check("R5 tx_full at depth", 32'(tx_full), 1);
    bus_write(8'h30, 32'h66600000);
    bus_write(8'h38, 32'h99999999);
    bus_write(8'h3C, 32'h0000DEAD);
    check("R5 tx_full held after discard", 32'(tx_full), 1);
    for (int k = 0; k < TXD; k++) begin
      check("R5 R2 order after discard id", tx_id, 32'h10000000 + 32'(k * 2));
      check("R5 order after discard dw2", tx_dw2, 32'(k));
      eng_pop();
      check("R6 pulse only on last", 32'(tx_empty_pulse), (k == TXD - 1) ? 1 : 0);
      if (k == 0) check("R5 tx_full released", 32'(tx_full), 0);
    end
    // R4 staging cleared by the discarded commit
    bus_write(8'h3C, 32'h0000ABCD);
    check("R4 cleared id", tx_id, 0);
    check("R4 cleared len", 32'(tx_len), 0);
    check("R4 cleared dw1", tx_dw1, 0);
    check("R4 dw2", tx_dw2, 32'h0000ABCD);
    eng_pop();

    // R7 R8 R9 R10 receive path
    eng_push(32'h12300000, 4'h3, 32'hA1A2A3A4, 32'hB1B2B3B4);
    check("R10 rx_ok on accept", 32'(rx_ok), 1);
    check("R11 no overflow", 32'(rx_overflow), 0);
    eng_push(32'h45600000, 4'h0, 32'h0, 32'h0);
    check("R10 rx_ok second", 32'(rx_ok), 1);
    check("R9 not empty", 32'(rx_not_empty), 1);
    bus_read(8'h50, v); check("R7 peek id", v, 32'h12300000);
    bus_read(8'h50, v); check("R7 id read does not pop", v, 32'h12300000);
    read_frame("R7", 32'h12300000, 4'h3, 32'hA1A2A3A4, 32'hB1B2B3B4);
    check("R9 still not empty", 32'(rx_not_empty), 1);
    bus_read(8'h50, v); check("R8 zero-length head id", v, 32'h45600000);
    bus_read(8'h5C, v); check("R8 zero-length dw2", v, 0);
    check("R8 R9 zero-length frame popped", 32'(rx_not_empty), 0);
    bus_read(8'h5C, v); check("R8 empty read zero", v, 0);
    bus_read(8'h50, v); check("R8 empty id read zero", v, 0);
    check("R8 empty stays empty", 32'(rx_not_empty), 0);
    eng_push(32'h7AB00000, 4'h2, 32'h5, 32'h6);
    read_frame("R8 after empty read", 32'h7AB00000, 4'h2, 32'h5, 32'h6);

    // R11 overflow
    for (int k = 0; k < RXD; k++) begin
      eng_push(32'h00200000 * (k + 1), 4'(k), 32'(k), 32'(k + 100));
      check("R10 rx_ok while filling", 32'(rx_ok), 1);
    end
    eng_push(32'hBAD00000, 4'h8, 32'hBAD, 32'hBAD);
    check("R11 overflow pulse", 32'(rx_overflow), 1);
    check("R11 no rx_ok on drop", 32'(rx_ok), 0);
    @(negedge clk);
    check("R11 overflow one cycle", 32'(rx_overflow), 0);
    for (int k = 0; k < RXD; k++)
      read_frame("R11 contents kept", 32'h00200000 * (k + 1), 4'(k), 32'(k), 32'(k + 100));
    check("R11 R9 dropped frame absent", 32'(rx_not_empty), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule